// File: doc/BRIEF.md
# Circular Trace Capture Buffer

This block is an on-chip circular memory for formatted trace words. While its enable bit is set, each valid 32-bit word from a trace port passes through a one-word formatter stage and is then written to RAM at the write pointer. The write pointer wraps around the memory, and a sticky flag records that a wrap has taken place, so software knows where the oldest surviving word is. A trigger input marks one word as the trigger point. After that word, a programmed number of further words is stored. Then acquisition is reported complete and no more words are written.

Software reaches all state through a small register bus: a 7-bit address, 32-bit data and a single strobe that carries a read/write direction. It sets the post-trigger count, clears the write pointer and sets the enable bit. It then polls status until acquisition is complete and the formatter is empty. To unload the trace, it sets the read pointer and reads the data port over and over. Each read of the data port returns one stored word and moves the read pointer forward.

Top module: `tcb_core`

## Requirements
- R1: After synchronous reset, the status register (address 3) reads 0x8, meaning only the formatter-empty bit is set. The read pointer, write pointer, trigger count and control register read 0, and `bus_rdata` is 0.
- R2: Address 0 returns the identification constant, address 1 returns the RAM depth in words, and address 2 returns the word width. Writes to these three addresses have no effect.
- R3: While control bit 0 (enable) is set, each cycle with `tr_valid` high stores `tr_word` at the write pointer (address 6), and the pointer then advances modulo the depth. While enable is clear, trace input is ignored.
- R4: A read of address 4 returns the word at the read pointer (address 5), and the read pointer then advances modulo the depth. The read pointer, write pointer and trigger count (address 7) can each be both written and read.
- R5: Status bit 0 (full) sets when the write pointer wraps from depth-1 to 0. It stays set until software writes the write pointer.
- R6: When a stored word carries `tr_trigger`, status bit 1 (triggered) sets. Each later stored word decrements the trigger count. Status bit 2 (acquisition complete) sets on the stored word that takes the count to 0, or on the trigger word itself if the count is already 0. Once it is set, nothing more is written to RAM.
- R7: A write to the control register that changes enable from 0 to 1 clears triggered and acquisition complete. Any other control write leaves them unchanged.
- R8: Status bit 3 (formatter empty) goes low at the edge that accepts a trace word. It returns high one edge after the last pending word has been committed to RAM.
- R9: Control bit 1 (demultiplexed port mode) is stored, and address 8 reads back both control bits.
- R10: Read data appears on `bus_rdata` in the cycle after the strobe edge. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tr_valid | input | 1 | Trace word present this cycle |
| tr_word | input | DW | Formatted trace word |
| tr_trigger | input | 1 | This word is the trigger point |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the strobe |

## Verification
Register reads are due exactly one edge after the strobe. The bench's monitor captures the strobe at that edge and compares `bus_rdata` at the next falling edge. A trace word is loaded into the formatter stage at edge k and committed to RAM at edge k+1, where the pointers and flags also change. Formatter-empty returns high at edge k+2. The bench therefore reads status back-to-back just after a single word, so the three reads fall on k+1, k+2 and k+3 and must return 0, 0 and 8. After bursts, it waits three idle cycles before it reads pointers or flags.

// File: rtl/tcb_pkg.sv
package tcb_pkg;
  localparam logic [6:0] A_ID    = 7'd0;
  localparam logic [6:0] A_DEPTH = 7'd1;
  localparam logic [6:0] A_WIDTH = 7'd2;
  localparam logic [6:0] A_STAT  = 7'd3;
  localparam logic [6:0] A_DATA  = 7'd4;
  localparam logic [6:0] A_RPTR  = 7'd5;
  localparam logic [6:0] A_WPTR  = 7'd6;
  localparam logic [6:0] A_TCNT  = 7'd7;
  localparam logic [6:0] A_CTRL  = 7'd8;

  // packed so that full lands on bit 0 and dfe on bit 3
  typedef struct packed {
    logic dfe;
    logic acq;
    logic trig;
    logic full;
  } tcb_status_t;
endpackage

// File: rtl/tcb_ram.sv
module tcb_ram #(
  parameter int AW = 4,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/tcb_capture.sv
module tcb_capture
  import tcb_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          clr_flags,
  input  logic          tr_valid,
  input  logic [DW-1:0] tr_word,
  input  logic          tr_trigger,
  input  logic          sw_wptr_we,
  input  logic          sw_tcnt_we,
  input  logic [31:0]   sw_wdata,
  output logic          ram_we,
  output logic [AW-1:0] ram_waddr,
  output logic [DW-1:0] ram_wdata,
  output logic [AW-1:0] wptr,
  output logic [31:0]   tcnt,
  output tcb_status_t   status
);
  localparam logic [AW-1:0] LAST = {AW{1'b1}};

  logic          pend_v, pend_t;
  logic [DW-1:0] pend_d;
  logic [AW-1:0] wptr_q;
  logic [31:0]   tcnt_q;
  logic          full_q, trig_q, acq_q, dfe_q;
  logic          load, commit;

  assign load   = en && tr_valid && !acq_q;
  assign commit = pend_v && !acq_q;

  // formatter stage: one word in flight between the port and RAM
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v <= 1'b0;
      pend_t <= 1'b0;
      pend_d <= '0;
    end else begin
      pend_v <= load;
      if (load) begin
        pend_d <= tr_word;
        pend_t <= tr_trigger;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q <= '0;
      full_q <= 1'b0;
    end else if (sw_wptr_we) begin
      wptr_q <= sw_wdata[AW-1:0];
      full_q <= 1'b0;
    end else if (commit) begin
      wptr_q <= wptr_q + 1'b1;
      if (wptr_q == LAST) full_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tcnt_q <= '0;
    end else if (sw_tcnt_we) begin
      tcnt_q <= sw_wdata;
    end else if (commit && trig_q && tcnt_q != 0) begin
      tcnt_q <= tcnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_q <= 1'b0;
      acq_q  <= 1'b0;
    end else if (clr_flags) begin
      trig_q <= 1'b0;
      acq_q  <= 1'b0;
    end else if (commit) begin
      if (!trig_q) begin
        if (pend_t) begin
          trig_q <= 1'b1;
          if (tcnt_q == 0) acq_q <= 1'b1;
        end
      end else if (tcnt_q <= 32'd1) begin
        acq_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) dfe_q <= 1'b1;
    else     dfe_q <= !load && !commit;
  end

  assign ram_we    = commit;
  assign ram_waddr = wptr_q;
  assign ram_wdata = pend_d;
  assign wptr      = wptr_q;
  assign tcnt      = tcnt_q;
  assign status    = '{dfe: dfe_q, acq: acq_q, trig: trig_q, full: full_q};

  AST_ACQ_FREEZES_WPTR: assert property (@(posedge clk) disable iff (rst)
    (acq_q && !sw_wptr_we) |=> $stable(wptr_q)); // R6
  AST_ACQ_AFTER_TRIG: assert property (@(posedge clk) disable iff (rst)
    acq_q |-> trig_q); // R6
  AST_FULL_STICKY: assert property (@(posedge clk) disable iff (rst)
    (full_q && !sw_wptr_we) |=> full_q); // R5
  AST_DFE_NO_PENDING: assert property (@(posedge clk) disable iff (rst)
    dfe_q |-> !pend_v); // R8
endmodule

// File: rtl/tcb_regs.sv
module tcb_regs
  import tcb_pkg::*;
#(
  parameter int          AW       = 4,
  parameter int          DW       = 32,
  parameter logic [31:0] ID_VALUE = 32'h7CB0_0001
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [6:0]    bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic [AW-1:0] wptr,
  input  logic [31:0]   tcnt,
  input  tcb_status_t   status,
  input  logic [DW-1:0] ram_rdata,
  output logic          ram_re,
  output logic [AW-1:0] ram_raddr,
  output logic          en,
  output logic          clr_flags,
  output logic          sw_wptr_we,
  output logic          sw_tcnt_we
);
  localparam int DEPTH = 1 << AW;

  logic          acc_wr, acc_rd;
  logic [1:0]    ctrl_q;
  logic [AW-1:0] rptr_q;
  logic [31:0]   reg_q;
  logic          sel_ram_q;

  assign acc_wr     = bus_sel && bus_wr;
  assign acc_rd     = bus_sel && !bus_wr;
  assign sw_wptr_we = acc_wr && bus_addr == A_WPTR;
  assign sw_tcnt_we = acc_wr && bus_addr == A_TCNT;
  assign clr_flags  = acc_wr && bus_addr == A_CTRL && bus_wdata[0] && !ctrl_q[0];
  assign ram_re     = acc_rd && bus_addr == A_DATA;
  assign ram_raddr  = rptr_q;
  assign en         = ctrl_q[0];

  always_ff @(posedge clk) begin
    if (rst)                               ctrl_q <= '0;
    else if (acc_wr && bus_addr == A_CTRL) ctrl_q <= bus_wdata[1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)                               rptr_q <= '0;
    else if (acc_wr && bus_addr == A_RPTR) rptr_q <= bus_wdata[AW-1:0];
    else if (ram_re)                       rptr_q <= rptr_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q     <= '0;
      sel_ram_q <= 1'b0;
    end else begin
      sel_ram_q <= ram_re;
      if (acc_rd) begin
        case (bus_addr)
          A_ID:    reg_q <= ID_VALUE;
          A_DEPTH: reg_q <= 32'(DEPTH);
          A_WIDTH: reg_q <= 32'(DW);
          A_STAT:  reg_q <= 32'(status);
          A_RPTR:  reg_q <= 32'(rptr_q);
          A_WPTR:  reg_q <= 32'(wptr);
          A_TCNT:  reg_q <= tcnt;
          A_CTRL:  reg_q <= 32'(ctrl_q);
          default: reg_q <= '0;
        endcase
      end
    end
  end

  assign bus_rdata = sel_ram_q ? 32'(ram_rdata) : reg_q;

  AST_RPTR_STEP: assert property (@(posedge clk) disable iff (rst)
    ram_re |=> rptr_q == $past(rptr_q) + 1'b1); // R4
  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !acc_wr |=> $stable(ctrl_q)); // R9
endmodule

// File: rtl/tcb_core.sv
module tcb_core
  import tcb_pkg::*;
#(
  parameter int          AW       = 4,
  parameter int          DW       = 32,
  parameter logic [31:0] ID_VALUE = 32'h7CB0_0001
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tr_valid,
  input  logic [DW-1:0] tr_word,
  input  logic          tr_trigger,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [6:0]    bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata
);
  logic          ram_we, ram_re;
  logic [AW-1:0] ram_waddr, ram_raddr, wptr;
  logic [DW-1:0] ram_wdata, ram_rdata;
  logic [31:0]   tcnt;
  tcb_status_t   status;
  logic          en, clr_flags, sw_wptr_we, sw_tcnt_we;

  tcb_regs #(.AW(AW), .DW(DW), .ID_VALUE(ID_VALUE)) regs_i (
    .clk(clk), .rst(rst),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wptr(wptr), .tcnt(tcnt), .status(status),
    .ram_rdata(ram_rdata), .ram_re(ram_re), .ram_raddr(ram_raddr),
    .en(en), .clr_flags(clr_flags),
    .sw_wptr_we(sw_wptr_we), .sw_tcnt_we(sw_tcnt_we)
  );

  tcb_capture #(.AW(AW), .DW(DW)) cap_i (
    .clk(clk), .rst(rst), .en(en), .clr_flags(clr_flags),
    .tr_valid(tr_valid), .tr_word(tr_word), .tr_trigger(tr_trigger),
    .sw_wptr_we(sw_wptr_we), .sw_tcnt_we(sw_tcnt_we), .sw_wdata(bus_wdata),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
    .wptr(wptr), .tcnt(tcnt), .status(status)
  );

  tcb_ram #(.AW(AW), .DW(DW)) ram_i (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .re(ram_re), .raddr(ram_raddr), .rdata(ram_rdata)
  );
endmodule

// File: tb/tcb_core_tb_top.sv
module tcb_core_tb_top;
  localparam logic [31:0] ID = 32'h7CB0_0001;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tr_valid = 1'b0, tr_trigger = 1'b0;
  logic [31:0] tr_word = '0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int vectors = 0;
  int errors  = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        cap = 1'b0;
  logic        done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  tcb_core #(.AW(4), .DW(32), .ID_VALUE(ID)) dut_i (
    .clk(clk), .rst(rst), .tr_valid(tr_valid), .tr_word(tr_word),
    .tr_trigger(tr_trigger), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  // monitor: a read accepted at an edge is compared at the following falling edge
  always @(posedge clk) cap <= bus_sel && !bus_wr && !rst;
  always @(negedge clk) begin
    if (cap) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      vectors++;
      if (bus_rdata !== e) begin
        errors++;
        $display("FAIL %s actual=%h expected=%h", t, bus_rdata, e);
      end
    end
  end

  // driver tasks: each is entered right after a falling edge
  task automatic rd(input logic [6:0] a, input logic [31:0] e, input string t);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic send(input logic [31:0] w, input logic t);
    tr_valid = 1'b1; tr_word = w; tr_trigger = t;
    @(negedge clk);
    tr_valid = 1'b0; tr_trigger = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(3, 32'h8, "R1 status");
    rd(5, 0, "R1 rptr");
    rd(6, 0, "R1 wptr");
    rd(7, 0, "R1 tcnt");
    rd(8, 0, "R1 ctrl");
    // R2 constants, writes ignored; R10 unmapped
    rd(0, ID, "R2 id");
    rd(1, 16, "R2 depth");
    rd(2, 32, "R2 width");
    wr(1, 5); wr(0, 0);
    rd(1, 16, "R2 depth after write");
    rd(0, ID, "R2 id after write");
    rd(9, 0, "R10 unmapped");
    // R3 disabled input is ignored
    send(32'hDEAD0000, 1'b0); send(32'hDEAD0001, 1'b1);
    idle(3);
    rd(6, 0, "R3 wptr while disabled");
    rd(3, 32'h8, "R3 status while disabled");
    // R3/R4 basic capture and readout
    wr(7, 100); wr(6, 0); wr(8, 1);
    for (int i = 0; i < 5; i++) send(32'hA000 + i, 1'b0);
    idle(3);
    rd(6, 5, "R3 wptr after 5");
    wr(5, 0);
    for (int i = 0; i < 5; i++) rd(4, 32'hA000 + i, "R4 data");
    rd(5, 5, "R4 rptr advanced");
    rd(3, 32'h8, "R8 idle status");
    // R8 formatter-empty timing
    send(32'hA005, 1'b0);
    rd(3, 32'h0, "R8 dfe low at commit");
    rd(3, 32'h0, "R8 dfe low one edge later");
    rd(3, 32'h8, "R8 dfe high again");
    // R5 wrap sets full; oldest word at wptr
    for (int i = 0; i < 12; i++) send(32'hB000 + i, 1'b0);
    idle(3);
    rd(3, 32'h9, "R5 full set");
    rd(6, 2, "R5 wptr wrapped");
    wr(5, 2);
    rd(4, 32'hA002, "R5 oldest word");
    wr(5, 15);
    rd(4, 32'hB009, "R4 last slot");
    rd(5, 0, "R4 rptr wrap");
    rd(4, 32'hB00A, "R4 slot 0");
    idle(2);
    rd(3, 32'h9, "R5 full sticky");
    wr(6, 0);
    rd(3, 32'h8, "R5 full cleared");
    // R6 trigger with 3 post-trigger words
    wr(8, 0); wr(7, 3); wr(6, 0); wr(8, 1);
    send(32'hC000, 1'b0); send(32'hC001, 1'b0); send(32'hC002, 1'b1);
    for (int i = 3; i < 8; i++) send(32'hC000 + i, 1'b0);
    idle(3);
    rd(3, 32'hE, "R6 triggered and complete");
    rd(6, 6, "R6 wptr stopped");
    rd(7, 0, "R6 tcnt exhausted");
    wr(5, 5);
    rd(4, 32'hC005, "R6 last stored");
    rd(4, 32'hB000, "R6 no write after complete");
    // R9 mode bit; R7 clear only on enable rising
    wr(8, 3);
    rd(8, 3, "R9 ctrl readback");
    rd(3, 32'hE, "R7 flags kept without rising enable");
    wr(8, 0);
    rd(8, 0, "R9 ctrl cleared");
    rd(3, 32'hE, "R7 flags kept on disable");
    wr(8, 1);
    rd(3, 32'h8, "R7 flags cleared on enable");
    idle(3);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule